// File: doc/BRIEF.md
# Counter with Holding Register

This block is a binary up-counter whose value can be copied into a separate holding register. The holding register drives a set of three-state parallel data lines. The counter and the holding register each have their own rising-edge clock. The counter also has an asynchronous active-low clear and an active-low count enable.

An active-low carry flag is decoded from the counter itself, not from the register. It goes low while every counter bit is one. Because the count enable is also active low, the carry of one stage can drive the count enable of the next stage directly, so several stages can be chained into a wider counter.

When one clock drives both clock inputs, the register captures the value from before the increment on that edge. The captured value therefore trails the counter by one count.

Top module: `cnt_hold_reg`

## Requirements
- R1: On a rising edge of `cnt_clk` with `cnt_clr_n` high and `cnt_en_n` low, the counter increases by exactly one.
- R2: On a rising edge of `cnt_clk` with `cnt_en_n` high, the counter keeps its value.
- R3: While `cnt_clr_n` is low, the counter is zero. The clear takes effect at once, without a clock edge, and it overrides counting. The holding register is not affected by the clear.
- R4: On a rising edge of `reg_clk`, the holding register loads the counter value present just before that edge. With no such edge, the register keeps its contents, whatever the counter does.
- R5: With `oe_n` low, `data_o` shows the holding register. With `oe_n` high, every bit of `data_o` is high impedance (z).
- R6: `carry_n` is 0 exactly when all counter bits are 1, and 1 otherwise. It follows the counter even when the holding register holds a different value.
- R7: From all ones, the next enabled count gives zero, and `carry_n` returns to 1 at the same edge.
- R8: When `cnt_clk` and `reg_clk` rise on the same edge with counting enabled, the register receives the pre-increment value. After the edge the counter is one ahead of the register.
- R9: Toggling `cnt_en_n` without a rising edge of `cnt_clk` never changes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk | input | 1 | Counter clock, rising edge |
| cnt_clr_n | input | 1 | Asynchronous counter clear, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| reg_clk | input | 1 | Holding register clock, rising edge |
| oe_n | input | 1 | Output enable for data_o, active low |
| data_o | output | W (8) | Three-state view of the holding register |
| carry_n | output | 1 | Active-low all-ones flag of the counter |

## Verification
The bench drives both clocks from a single gated source. This lets it produce separate counter edges, separate register edges and shared edges. A design that captured the post-increment value on a shared edge would show the register equal to the counter, rather than one count behind it.

The bench counts through the full range into the wrap. A design with a carry decoded from the register, or a carry that failed to clear on wrap, would mismatch there.

It drops the clear between clock edges while the counter is at all ones. A synchronous clear would leave the carry low until the next edge, and a clear that reached the register would corrupt its contents.

The bench also toggles the enable between counter edges and checks for spurious counts. It checks the data lines for high impedance whenever the output enable is high.

// File: rtl/cnt_hold_pkg.sv
package cnt_hold_pkg;
  localparam int unsigned CNT_W_DEFAULT = 8;

  // True when every bit of the supplied word is set.
  function automatic logic all_set(input logic [63:0] val, input int unsigned w);
    logic res;
    res = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w) res = res & val[i];
    end
    return res;
  endfunction
endpackage

// File: rtl/hr_counter.sv
module hr_counter #(
  parameter int unsigned W = cnt_hold_pkg::CNT_W_DEFAULT
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         en_n,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] STEP = W'(1);

  logic [W-1:0] cnt_nx;
  logic         adv;

  // Count-enable is evaluated only at the clock edge through this mux.
  always_comb begin
    adv    = ~en_n;
    cnt_nx = cnt_q;
    if (adv) cnt_nx = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/hr_full_detect.sv
module hr_full_detect #(
  parameter int unsigned W = cnt_hold_pkg::CNT_W_DEFAULT
) (
  input  logic [W-1:0] cnt,
  output logic         full_n
);
  localparam int unsigned PADW = 64;

  logic [PADW-1:0] padded;

  always_comb begin
    padded        = '0;
    padded[W-1:0] = cnt;
    full_n        = ~cnt_hold_pkg::all_set(padded, W);
  end
endmodule

// File: rtl/hr_hold_reg.sv
module hr_hold_reg #(
  parameter int unsigned W = cnt_hold_pkg::CNT_W_DEFAULT
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] hold_q
);
  logic [W-1:0] hold_nx;

  always_comb hold_nx = din;

  // No reset: contents change only on a capture edge.
  always_ff @(posedge clk) begin
    hold_q <= hold_nx;
  end
endmodule

// File: rtl/hr_out_drive.sv
module hr_out_drive #(
  parameter int unsigned W = cnt_hold_pkg::CNT_W_DEFAULT
) (
  input  logic         oe_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] pad
);
  assign pad = oe_n ? {W{1'bz}} : din;
endmodule

// File: rtl/cnt_hold_reg.sv
module cnt_hold_reg #(
  parameter int unsigned W = cnt_hold_pkg::CNT_W_DEFAULT
) (
  input  logic         cnt_clk,
  input  logic         cnt_clr_n,
  input  logic         cnt_en_n,
  input  logic         reg_clk,
  input  logic         oe_n,
  output logic [W-1:0] data_o,
  output logic         carry_n
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] hold_q;

  hr_counter #(.W(W)) u_cnt (
    .clk   (cnt_clk),
    .clr_n (cnt_clr_n),
    .en_n  (cnt_en_n),
    .cnt_q (cnt_q)
  );

  hr_full_detect #(.W(W)) u_full (
    .cnt    (cnt_q),
    .full_n (carry_n)
  );

  hr_hold_reg #(.W(W)) u_hold (
    .clk    (reg_clk),
    .din    (cnt_q),
    .hold_q (hold_q)
  );

  hr_out_drive #(.W(W)) u_drv (
    .oe_n (oe_n),
    .din  (hold_q),
    .pad  (data_o)
  );
endmodule

// File: rtl/cnt_hold_reg_chk.sv
module cnt_hold_reg_chk #(
  parameter int unsigned W = cnt_hold_pkg::CNT_W_DEFAULT
) (
  input logic         cnt_clk,
  input logic         cnt_clr_n,
  input logic         cnt_en_n,
  input logic         reg_clk,
  input logic         carry_n,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] hold_q
);
  logic [W-1:0] smp = '0;
  logic         seen = 1'b0;

  // Enabled edge adds exactly one (R1)
  p_count_step_r1: assert property (@(posedge cnt_clk) disable iff (!cnt_clr_n)
    !cnt_en_n |=> cnt_q == $past(cnt_q) + W'(1));

  // Disabled edge keeps the count (R2)
  p_count_hold_r2: assert property (@(posedge cnt_clk) disable iff (!cnt_clr_n)
    cnt_en_n |=> $stable(cnt_q));

  // Carry low plus enabled edge wraps to zero with carry released (R7)
  p_wrap_r7: assert property (@(posedge cnt_clk) disable iff (!cnt_clr_n)
    (!carry_n && !cnt_en_n) |=> (cnt_q == '0 && carry_n));

  // Register holds the counter value seen at the capture edge (R4)
  always_ff @(posedge reg_clk) begin
    smp  <= cnt_q;
    seen <= 1'b1;
  end

  always @(negedge reg_clk) begin
    if (seen) p_capture_r4: assert (hold_q == smp);
  end
endmodule

bind cnt_hold_reg cnt_hold_reg_chk #(.W(W)) u_chk (
  .cnt_clk   (cnt_clk),
  .cnt_clr_n (cnt_clr_n),
  .cnt_en_n  (cnt_en_n),
  .reg_clk   (reg_clk),
  .carry_n   (carry_n),
  .cnt_q     (cnt_q),
  .hold_q    (hold_q)
);

// File: tb/sim_cnt_hold_reg.sv
`timescale 1ns/1ps
module sim_cnt_hold_reg;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic cg = 1'b0, rg = 1'b0;
  logic clr_n = 1'b0, en_n = 1'b1, oe_n = 1'b1;
  wire  cnt_clk = clk & cg;
  wire  reg_clk = clk & rg;
  wire [W-1:0] data_o;
  wire  carry_n;

  int n_chk = 0, n_fail = 0;
  int ref_cnt = 0, ref_hold = 0;
  bit hold_ok = 0;
  string tag = "R3";

  always #10 clk = ~clk;

  cnt_hold_reg #(.W(W)) u0 (
    .cnt_clk(cnt_clk), .cnt_clr_n(clr_n), .cnt_en_n(en_n),
    .reg_clk(reg_clk), .oe_n(oe_n), .data_o(data_o), .carry_n(carry_n)
  );

  // Behavioural reference model.
  always @(posedge clk) begin
    int old;
    old = ref_cnt;
    if (!clr_n) ref_cnt = 0;
    else if (cg && !en_n) ref_cnt = (ref_cnt + 1) & MASK;
    if (rg) begin ref_hold = old; hold_ok = 1; end
  end

  task automatic chk_carry(input string t);
    logic exp;
    exp = (ref_cnt == MASK) ? 1'b0 : 1'b1;
    n_chk++;
    if (carry_n !== exp) begin
      n_fail++;
      $display("FAIL %s carry_n got %b exp %b", t, carry_n, exp);
    end
  endtask

  task automatic chk_data(input string t);
    logic [W-1:0] exp;
    if (oe_n) exp = {W{1'bz}};
    else if (hold_ok) exp = W'(ref_hold);
    else return;
    n_chk++;
    if (data_o !== exp) begin
      n_fail++;
      $display("FAIL %s data_o got %h exp %h", t, data_o, exp);
    end
  endtask

  task automatic chk_all();
    chk_carry((tag == "R7" || tag == "R3") ? tag : "R6");
    chk_data(oe_n ? "R5" : tag);
  endtask

  task automatic step(input bit c, input bit r, input bit e, input bit o);
    cg = c; rg = r; en_n = e; oe_n = o;
    @(negedge clk);
    chk_all();
  endtask

  // Enable toggles inside the high phase, no counter edge follows (R9).
  task automatic step_glitch(input bit c);
    cg = c; rg = 1'b0; oe_n = 1'b0;
    @(posedge clk);
    #3 en_n = ~en_n;
    #3 en_n = ~en_n;
    #2 en_n = ~en_n;
    @(negedge clk);
    chk_all();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R3: cleared state, clocks running into the counter
    tag = "R3";
    repeat (3) step(1, 0, 0, 1);
    step(0, 1, 0, 0);            // capture zero while cleared
    // R1: count five, register stays at 0 (R4)
    clr_n = 1'b1;
    tag = "R1";
    repeat (5) step(1, 0, 0, 0);
    tag = "R4";
    step(0, 1, 1, 0);            // capture 5
    step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    // R2: disabled counter edges
    tag = "R2";
    repeat (4) step(1, 0, 1, 0);
    step(0, 1, 1, 0);
    // R8: shared edges
    tag = "R8";
    repeat (6) step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    // R9: enable wiggles with no counter edge
    tag = "R9";
    en_n = 1'b1;
    repeat (3) step_glitch(0);
    repeat (2) step_glitch(1);
    step(0, 1, 1, 0);
    // R5: output float and re-drive
    tag = "R5";
    step(0, 0, 1, 1);
    step(1, 0, 0, 1);
    step(0, 1, 1, 0);
    // R6/R7: run up to all ones and wrap
    tag = "R6";
    while (ref_cnt != MASK) step(1, 0, 0, 0);
    step(0, 1, 1, 0);            // register holds all ones
    tag = "R7";
    step(1, 0, 0, 0);            // wraps to zero
    step(0, 1, 1, 0);
    // R3: asynchronous clear at all ones, register untouched
    tag = "R6";
    while (ref_cnt != MASK) step(1, 0, 0, 0);
    step(0, 1, 1, 0);
    tag = "R3";
    cg = 1'b0; rg = 1'b0;
    #3 clr_n = 1'b0;
    ref_cnt = 0;
    #2;
    chk_carry("R3");
    chk_data("R3");
    @(negedge clk);
    chk_all();
    step(1, 0, 0, 0);            // clear overrides enabled count
    step(0, 1, 0, 0);            // capture zero
    clr_n = 1'b1;
    tag = "R1";
    repeat (3) step(1, 0, 0, 0);
    step(0, 1, 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule